// File: doc/BRIEF.md
# Line-Cycle Synchronous Energy Accumulator

This block integrates a stream of per-sample power values into an energy total. The length of each total is set by line zero crossings, not by clock cycles. Software programs a whole number of half-cycles. The block waits for a zero crossing and then sums every valid sample until that many further crossings have passed. At the crossing that completes the window it latches a slice of the running sum as the result and raises a sticky cycle-end flag. The next window starts in the same cycle, so no sample is lost.

Reprogramming the half-cycle count discards the partial sum and the old result. Accumulation then waits for the next crossing, so the first cycle-end event after a write always reports a complete window. A count of zero parks the block. The interrupt request is the cycle-end flag gated by an enable input. Zero-crossing detection, the power computation and gain scaling are done elsewhere.

Top module: `half_cycle_energy_acc`

## Requirements
- R1: The half-cycle count is an unsigned 16-bit value. With count N, the window opened at a zero crossing closes at the Nth zero crossing after it, for any N up to 65,535.
- R2: A count write (`cntWrEn`) sets `energyOut` and the running sum to zero in the next cycle. Samples that arrive before the next zero crossing are not summed.
- R3: At the closing crossing, `energyOut` takes bits [RES_LSB+23:RES_LSB] of the window sum, with RES_LSB = 8 by default. It changes only at such a crossing or at a count write.
- R4: A sample that arrives in a zero-crossing cycle that opens or closes a window belongs to the new window. Consecutive windows run back to back.
- R5: `cycleEndFlag` is zero after reset and is set when a window closes. It is cleared only by `flagWrEn` with `flagWrData` = 1. A set and a clear in the same cycle leave it set.
- R6: `irqReq` is 1 exactly when `cycleEndFlag` and `irqEnable` are both 1.
- R7: A count of zero stops accumulation. No window closes, `cycleEndFlag` is never set, and `energyOut` stays 0.
- R8: With SIGNED_PWR = 1 (the default), `samplePower` is two's complement and is sign-extended into the sum. A negative window total gives a negative result slice.
- R9: A count write in the same cycle as a zero crossing takes priority. That crossing does not open the window, and the next crossing does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Power sample strobe |
| samplePower | input | 24 | Power sample value |
| zeroCross | input | 1 | One-cycle zero-crossing pulse |
| cntWrEn | input | 1 | Half-cycle count write strobe |
| cntWrData | input | 16 | Half-cycle count write value |
| flagWrEn | input | 1 | Status write strobe |
| flagWrData | input | 1 | Status write value; 1 clears the cycle-end flag |
| irqEnable | input | 1 | Cycle-end interrupt enable |
| energyOut | output | 24 | Latched window energy |
| cycleEndFlag | output | 1 | Sticky cycle-end status |
| irqReq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle:
- A window closing and a software clear of the flag.
- A count write and a zero crossing.

Directed sequences place each pair on exactly one edge. The flag must remain set after the first pair. After the second pair, a known result must appear only after two further crossings. Random traffic also produces these collisions, and a bench reference model judges every cycle.

// File: rtl/hce_pkg.sv
package hce_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} hce_state_t;

  typedef struct packed {
    logic clearAll;
    logic startWin;
    logic closeWin;
    logic takeSample;
  } hce_strobe_t;
endpackage

// File: rtl/hce_ctrl.sv
module hce_ctrl
  import hce_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             zeroCross,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             flagWrEn,
  input  logic             flagWrData,
  input  logic             irqEnable,
  output hce_strobe_t      strobes,
  output logic             cycleEndFlag,
  output logic             irqReq
);
  hce_state_t       state;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] halfCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             windowDone;

  assign nextCnt    = halfCnt + 1'b1;
  assign windowDone = (state == ST_RUN) && zeroCross && (nextCnt == target);

  always_comb begin
    strobes            = '0;
    strobes.clearAll   = cntWrEn;
    strobes.startWin   = !cntWrEn && (state == ST_ARM) && zeroCross;
    strobes.closeWin   = !cntWrEn && windowDone;
    strobes.takeSample = !cntWrEn && sampleValid &&
                         ((state == ST_RUN) || strobes.startWin);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      target  <= '0;
      halfCnt <= '0;
    end else if (cntWrEn) begin
      target  <= cntWrData;
      halfCnt <= '0;
      state   <= (cntWrData == '0) ? ST_IDLE : ST_ARM;
    end else if (strobes.startWin) begin
      state   <= ST_RUN;
      halfCnt <= '0;
    end else if (state == ST_RUN && zeroCross) begin
      halfCnt <= windowDone ? '0 : nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cycleEndFlag <= 1'b0;
    else if (strobes.closeWin)
      cycleEndFlag <= 1'b1;
    else if (flagWrEn && flagWrData)
      cycleEndFlag <= 1'b0;
  end

  assign irqReq = cycleEndFlag && irqEnable;
endmodule

// File: rtl/hce_datapath.sv
module hce_datapath
  import hce_pkg::*;
#(
  parameter int PWR_W      = 24,
  parameter int ACC_W      = 48,
  parameter int RES_W      = 24,
  parameter int RES_LSB    = 8,
  parameter bit SIGNED_PWR = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  hce_strobe_t      strobes,
  input  logic [PWR_W-1:0] samplePower,
  output logic [RES_W-1:0] energyOut
);
  localparam int EXT_W = ACC_W - PWR_W;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] extPwr;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] addend;

  generate
    if (SIGNED_PWR) begin : g_signed
      assign extPwr = {{EXT_W{samplePower[PWR_W-1]}}, samplePower};
    end else begin : g_unsigned
      assign extPwr = {{EXT_W{1'b0}}, samplePower};
    end
  endgenerate

  assign base   = (strobes.startWin || strobes.closeWin) ? '0 : accReg;
  assign addend = strobes.takeSample ? extPwr : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg    <= '0;
      energyOut <= '0;
    end else if (strobes.clearAll) begin
      accReg    <= '0;
      energyOut <= '0;
    end else begin
      if (strobes.closeWin)
        energyOut <= accReg[RES_LSB +: RES_W];
      if (strobes.startWin || strobes.closeWin || strobes.takeSample)
        accReg <= base + addend;
    end
  end
endmodule

// File: rtl/half_cycle_energy_acc.sv
module half_cycle_energy_acc
  import hce_pkg::*;
#(
  parameter int PWR_W      = 24,
  parameter int ACC_W      = 48,
  parameter int RES_W      = 24,
  parameter int RES_LSB    = 8,
  parameter int CNT_W      = 16,
  parameter bit SIGNED_PWR = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [PWR_W-1:0] samplePower,
  input  logic             zeroCross,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             flagWrEn,
  input  logic             flagWrData,
  input  logic             irqEnable,
  output logic [RES_W-1:0] energyOut,
  output logic             cycleEndFlag,
  output logic             irqReq
);
  hce_strobe_t strobes;

  hce_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .zeroCross    (zeroCross),
    .cntWrEn      (cntWrEn),
    .cntWrData    (cntWrData),
    .flagWrEn     (flagWrEn),
    .flagWrData   (flagWrData),
    .irqEnable    (irqEnable),
    .strobes      (strobes),
    .cycleEndFlag (cycleEndFlag),
    .irqReq       (irqReq)
  );

  hce_datapath #(
    .PWR_W      (PWR_W),
    .ACC_W      (ACC_W),
    .RES_W      (RES_W),
    .RES_LSB    (RES_LSB),
    .SIGNED_PWR (SIGNED_PWR)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .samplePower (samplePower),
    .energyOut   (energyOut)
  );
endmodule

// File: rtl/hce_checker.sv
module hce_checker #(
  parameter int RES_W = 24,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             zeroCross,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             flagWrEn,
  input logic             flagWrData,
  input logic             irqEnable,
  input logic [RES_W-1:0] energyOut,
  input logic             cycleEndFlag,
  input logic             irqReq
);
  logic [CNT_W-1:0] lastCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lastCnt <= '0;
    else if (cntWrEn) lastCnt <= cntWrData;
  end

  p_wr_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> energyOut == '0);

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!zeroCross && !cntWrEn) |=> $stable(energyOut));

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycleEndFlag) |-> $past(zeroCross));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEndFlag && !(flagWrEn && flagWrData)) |=> cycleEndFlag);

  p_irq_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cycleEndFlag && irqEnable) |-> irqReq);

  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable || !cycleEndFlag) |-> !irqReq);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lastCnt == '0 && !cntWrEn) |=> !$rose(cycleEndFlag));

  p_wr_no_close_r9: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> !$rose(cycleEndFlag));
endmodule

bind half_cycle_energy_acc hce_checker #(.RES_W(RES_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/half_cycle_energy_acc_tb_top.sv
module half_cycle_energy_acc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] samplePower = '0;
  logic        zeroCross = 1'b0;
  logic        cntWrEn = 1'b0;
  logic [15:0] cntWrData = '0;
  logic        flagWrEn = 1'b0;
  logic        flagWrData = 1'b0;
  logic        irqEnable = 1'b0;
  logic [23:0] energyOut;
  logic        cycleEndFlag;
  logic        irqReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int          mState = 0;   // 0 idle, 1 armed, 2 running
  logic [15:0] mTarget = '0;
  int          mCnt = 0;
  logic [47:0] mAcc = '0;
  logic [23:0] mEnergy = '0;
  bit          mFlag = 1'b0;

  always #5 clk = ~clk;

  half_cycle_energy_acc dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .samplePower(samplePower),
    .zeroCross(zeroCross), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData), .irqEnable(irqEnable),
    .energyOut(energyOut), .cycleEndFlag(cycleEndFlag), .irqReq(irqReq)
  );

  function automatic logic [47:0] extend(input logic [23:0] p);
    return {{24{p[23]}}, p};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input bit v, input logic [23:0] p, input bit zc,
                           input bit wr, input logic [15:0] wd, input bit clr);
    bit setF = 1'b0;
    if (wr) begin
      mTarget = wd; mAcc = '0; mEnergy = '0; mCnt = 0;
      mState = (wd == 0) ? 0 : 1;
    end else if (mState == 1 && zc) begin
      mState = 2; mCnt = 0; mAcc = v ? extend(p) : '0;
    end else if (mState == 2) begin
      if (zc && (mCnt + 1 == int'(mTarget))) begin
        mEnergy = mAcc[8 +: 24]; setF = 1'b1; mCnt = 0;
        mAcc = v ? extend(p) : '0;
      end else begin
        if (zc) mCnt++;
        if (v) mAcc = mAcc + extend(p);
      end
    end
    if (setF) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
  endtask

  // one clock: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input bit v, input logic [23:0] p, input bit zc,
                     input bit wr, input logic [15:0] wd, input bit clr, input bit chk);
    sampleValid = v; samplePower = p; zeroCross = zc;
    cntWrEn = wr; cntWrData = wd; flagWrEn = clr; flagWrData = clr;
    @(posedge clk);
    modelStep(v, p, zc, wr, wd, clr);
    @(negedge clk);
    sampleValid = 0; zeroCross = 0; cntWrEn = 0; flagWrEn = 0; flagWrData = 0;
    if (chk) begin
      check(energyOut == mEnergy, "R3 energyOut vs model", energyOut, mEnergy);
      check(cycleEndFlag == mFlag, "R5 cycleEndFlag vs model", cycleEndFlag, mFlag);
      check(irqReq == (mFlag && irqEnable), "R6 irqReq", irqReq, mFlag && irqEnable);
    end
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(energyOut == 0, "R3 reset energyOut", energyOut, 0);
    check(cycleEndFlag == 0, "R5 reset cycleEndFlag", cycleEndFlag, 0);
    check(irqReq == 0, "R6 reset irqReq", irqReq, 0);

    // R7: count zero parks the block
    cyc(0, 0, 0, 1, 16'd0, 0, 1);
    for (int i = 0; i < 20; i++) cyc(1, 24'h4000, (i % 3) == 0, 0, 0, 0, 1);
    check(energyOut == 0, "R7 idle energyOut", energyOut, 0);
    check(cycleEndFlag == 0, "R7 idle flag", cycleEndFlag, 0);

    // R2 / R4: samples before the first crossing are ignored
    irqEnable = 1'b1;
    cyc(0, 0, 0, 1, 16'd2, 0, 1);
    cyc(1, 24'h001000, 0, 0, 0, 0, 1);
    cyc(1, 24'h000200, 1, 0, 0, 0, 1);
    cyc(1, 24'h000300, 0, 0, 0, 0, 1);
    cyc(1, 24'h000500, 1, 0, 0, 0, 1);
    cyc(1, 24'h000700, 1, 0, 0, 0, 1);
    check(energyOut == 24'h00000A, "R2 first window after write", energyOut, 24'hA);
    check(cycleEndFlag == 1, "R5 flag set on close", cycleEndFlag, 1);
    check(irqReq == 1, "R6 irq with enable", irqReq, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    check(energyOut == 24'h000007, "R4 boundary sample in next window", energyOut, 24'h7);

    // R5: close and clear in the same cycle keeps the flag
    cyc(0, 0, 0, 0, 0, 1, 1);
    check(cycleEndFlag == 0, "R5 w1c clears", cycleEndFlag, 0);
    cyc(0, 0, 1, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 1, 1);
    check(cycleEndFlag == 1, "R5 set beats clear", cycleEndFlag, 1);
    irqEnable = 1'b0;
    #1;
    check(irqReq == 0, "R6 irq masked", irqReq, 0);
    cyc(0, 0, 0, 0, 0, 1, 1);

    // R9: write and crossing together; the next crossing opens the window
    cyc(1, 24'h000400, 1, 1, 16'd1, 0, 1);
    cyc(1, 24'h000800, 0, 0, 0, 0, 1);
    cyc(1, 24'h000100, 1, 0, 0, 0, 1);
    cyc(1, 24'h000100, 0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    check(energyOut == 24'h000002, "R9 write wins over crossing", energyOut, 24'h2);

    // R8: negative total
    cyc(0, 0, 0, 1, 16'd1, 1, 1);
    cyc(1, 24'hFFFD00, 1, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0, 0, 1);
    check(energyOut == 24'hFFFFFD, "R8 signed result", energyOut, 24'hFFFFFD);

    // R1: long window of 0x8001 half cycles, one crossing per clock
    cyc(0, 0, 0, 1, 16'h8001, 1, 1);
    cyc(1, 24'h000100, 1, 0, 0, 0, 0);
    for (int i = 0; i < 32768; i++) cyc(1, 24'h000100, 1, 0, 0, 0, 0);
    check(cycleEndFlag == 0, "R1 no close before count", cycleEndFlag, 0);
    cyc(0, 0, 1, 0, 0, 0, 1);
    check(energyOut == 24'h008001, "R1 long window", energyOut, 24'h8001);
    check(cycleEndFlag == 1, "R1 close at count", cycleEndFlag, 1);

    // random traffic against the model
    for (int w = 0; w < 40; w++) begin
      cyc(0, 0, ($urandom % 2) == 0, 1, 16'($urandom % 6), $urandom % 2, 1);
      irqEnable = $urandom % 2;
      for (int i = 0; i < 60; i++) begin
        logic [23:0] p;
        p = 24'($signed(int'($urandom % 65536) - 32768));
        cyc($urandom % 3 != 0, p, ($urandom % 5) == 0, 0, 0, ($urandom % 13) == 0, 1);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule